// File: doc/BRIEF.md
# Repeating Pattern Serial Oscillator

This block turns a stored 128-bit bit pattern into a periodic serial waveform. Four 32-bit pattern words sit in writable registers. A word index walks through them in order: word 0, 1, 2, 3, then back to 0. Each selected word is handed to a parallel-to-serial shifter, which sends it out one bit per clock. Software sets the frequency and the duty cycle of the serial output by choosing the pattern. An alternating pattern gives the fastest square wave. Long runs of ones and zeros give slower waves or asymmetric ones.

The selected word is also shown on a parallel output, together with a strobe that marks the clock in which the shifter takes it. A downstream serializer can use either the parallel word or the bit stream. Every pattern word can be read back through a combinational read port. Software can rewrite any word while the block runs, and a new value is picked up the next time that word is selected.

Top module: `pattern_osc`

## Requirements
- R1: After reset all four pattern words read as zero, the word index points at word 0, `ser_out` is 0 and `load_stb` is 1 before the first clock edge.
- R2: `load_stb` is high for exactly one clock in every 32. It is first high in the cycle that ends with the first rising edge after reset is released.
- R3: The shifter sends the loaded word least significant bit first, one bit per clock. Bit k of a word loaded at edge e is on `ser_out` in the cycle after edge e+k, for k = 0..31, so the output has no gaps between words.
- R4: Words are loaded in index order 0, 1, 2, 3, 0, and so on. While `load_stb` is high, `word_out` equals the pattern word that will be loaded at the next edge.
- R5: A write to a pattern word takes effect the next time that word is selected. A word already in the shifter is not altered. A write that lands on the same edge as the load of that word still loads the old value.
- R6: `rd_data` shows the pattern word addressed by `rd_addr` (offsets 0 to 3) combinationally. A written value is visible from the cycle after the write.
- R7: With all words set to 0x55555555, `ser_out` toggles on every clock.
- R8: With every word set to 0x0000FFFF, `ser_out` is high for 16 clocks and then low for 16 clocks, repeating.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Pattern word write enable |
| wr_addr | input | 2 | Pattern word index to write |
| wr_data | input | 32 | Pattern word write value |
| rd_addr | input | 2 | Pattern word index to read |
| rd_data | output | 32 | Read-back value of the addressed pattern word |
| word_out | output | 32 | Pattern word currently selected for loading |
| load_stb | output | 1 | High in the clock whose closing edge loads `word_out` into the shifter |
| ser_out | output | 1 | Serial pattern output, least significant bit first |

## Verification
A wrong bit counter moves the load strobe away from its fixed 32-clock spacing. It also stretches or cuts a word on the serial line, and this shows up within one word time of the fault. A wrong word index puts the wrong word, or the wrong order of words, on `word_out` at the next strobe. The serial line then differs from the stored pattern in the next 32 clocks. A write that corrupts the word in flight, or that the bank misses, shows on `ser_out` within one full 128-clock pattern period. A bank fault also shows on `rd_data` in the very next cycle.

// File: rtl/osc_pkg.sv
package osc_pkg;
    // Step an index through 0..count-1 and wrap back to 0.
    function automatic int unsigned wrap_next(input int unsigned cur, input int unsigned count);
        return (cur + 1 >= count) ? 0 : cur + 1;
    endfunction
endpackage

// File: rtl/osc_pattern_bank.sv
module osc_pattern_bank #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 4,
    localparam int IDX_W    = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic [WORD_W-1:0] rd_data,
    input  logic [IDX_W-1:0]  sel_idx,
    output logic [WORD_W-1:0] sel_word
);
    logic [WORD_W-1:0] word_q [NUM_WORDS];

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        typedef struct packed {
            logic [WORD_W-1:0] value;
        } slot_t;
        slot_t slot_d, slot_q;

        always_comb begin
            slot_d = slot_q;
            if (wr_en && (int'(wr_addr) == g)) begin
                slot_d.value = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) slot_q <= '0;
            else        slot_q <= slot_d;
        end

        assign word_q[g] = slot_q.value;

        // R6: a write lands in the addressed word one edge later
        assert_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && int'(wr_addr) == g) |=> (word_q[g] == $past(wr_data)));
        // R5: a word nobody writes keeps its value
        assert_word_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && int'(wr_addr) == g) |=> $stable(word_q[g]));
    end

    assign rd_data  = word_q[rd_addr];
    assign sel_word = word_q[sel_idx];
endmodule

// File: rtl/osc_sequencer.sv
module osc_sequencer #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 4,
    localparam int IDX_W    = $clog2(NUM_WORDS),
    localparam int CNT_W    = $clog2(WORD_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [IDX_W-1:0] sel_idx,
    output logic             load_stb
);
    import osc_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] bit_cnt;
        logic [IDX_W-1:0] idx;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        seq_d.bit_cnt = CNT_W'(wrap_next(int'(seq_q.bit_cnt), WORD_W));
        if (seq_q.bit_cnt == '0) begin
            seq_d.idx = IDX_W'(wrap_next(int'(seq_q.idx), NUM_WORDS));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign sel_idx  = seq_q.idx;
    assign load_stb = (seq_q.bit_cnt == '0);

    // R2: the strobe never lasts two clocks in a row
    assert_stb_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> !load_stb);
    // R2: the last bit slot is always followed by a strobe
    assert_stb_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.bit_cnt == CNT_W'(WORD_W - 1)) |=> load_stb);
    // R4: the index moves only across a load
    assert_idx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !load_stb |=> $stable(sel_idx));
    // R4: after a load the index has moved to a different word
    assert_idx_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> (sel_idx != $past(sel_idx)));
endmodule

// File: rtl/osc_shifter.sv
module osc_shifter #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    output logic              ser_out
);
    typedef struct packed {
        logic [WORD_W-1:0] shreg;
    } shf_t;

    shf_t shf_d, shf_q;

    always_comb begin
        shf_d = shf_q;
        if (load) shf_d.shreg = word_in;
        else      shf_d.shreg = {1'b0, shf_q.shreg[WORD_W-1:1]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) shf_q <= '0;
        else        shf_q <= shf_d;
    end

    assign ser_out = shf_q.shreg[0];

    // R3: the first bit out after a load is the word's LSB
    assert_lsb_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (ser_out == $past(word_in[0])));
    // R5: between loads the register only shifts, so outside data cannot alter it
    assert_no_midword_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (shf_q.shreg[WORD_W-2:0] == $past(shf_q.shreg[WORD_W-1:1])));
endmodule

// File: rtl/pattern_osc.sv
module pattern_osc #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 4,
    localparam int IDX_W    = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic [WORD_W-1:0] word_out,
    output logic              load_stb,
    output logic              ser_out
);
    logic [IDX_W-1:0] sel_idx;

    osc_sequencer #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_idx  (sel_idx),
        .load_stb (load_stb)
    );

    osc_pattern_bank #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .sel_idx  (sel_idx),
        .sel_word (word_out)
    );

    osc_shifter #(.WORD_W(WORD_W)) u_shf (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_stb),
        .word_in (word_out),
        .ser_out (ser_out)
    );

    // R1: the cycle right after reset is a load slot for word 0
    assert_reset_start_R1: assert property (@(posedge clk)
        !rst_n |=> (load_stb && sel_idx == '0 && !ser_out));
endmodule

// File: tb/pattern_osc_tb.sv
module pattern_osc_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [31:0] word_out;
    logic        load_stb;
    logic        ser_out;

    int n_tests = 0;
    int n_fail  = 0;

    // Bench model of the requirements
    logic [31:0] m_bank [4];
    logic [31:0] m_shift;
    int          m_cnt;
    int          m_idx;

    // Stimulus table: four 128-bit patterns, word 0 in the low 32 bits
    localparam logic [127:0] PATS [4] = '{
        128'hAAAAAAAA_AAAAAAAA_AAAAAAAA_AAAAAAAA,
        128'h0000FFFF_F0F0F0F0_12345678_80000001,
        128'hFFFFFFFF_00000000_FFFFFFFF_00000000,
        128'hDEADBEEF_CAFEF00D_0F1E2D3C_76543210
    };

    always #(CLK_PERIOD/2) clk = ~clk;

    pattern_osc u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .word_out (word_out),
        .load_stb (load_stb),
        .ser_out  (ser_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4; i++) m_bank[i] = '0;
        m_shift = '0; m_cnt = 0; m_idx = 0;
    endtask

    // Called at a falling edge: compare the outputs with the model
    task automatic check_outputs();
        check("R3 ser_out", {31'd0, ser_out}, {31'd0, m_shift[0]});
        check("R2 load_stb", {31'd0, load_stb}, {31'd0, (m_cnt == 0)});
        if (load_stb) check("R4 word_out", word_out, m_bank[m_idx]);
    endtask

    // One clock: drive inputs, advance the model at the rising edge, check at the falling edge
    task automatic tick(input logic we, input int a, input logic [31:0] d);
        wr_en = we; wr_addr = 2'(a); wr_data = d;
        @(posedge clk);
        if (m_cnt == 0) begin
            m_shift = m_bank[m_idx];
            m_idx = (m_idx + 1) % 4;
        end else begin
            m_shift = m_shift >> 1;
        end
        m_cnt = (m_cnt + 1) % 32;
        if (we) m_bank[a] = d;
        @(negedge clk);
        wr_en = 1'b0;
        check_outputs();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        model_reset();
        rst_n = 1'b1;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] old_w;
        int ones;
        do_reset();

        // R1: reset state, before the first edge after release
        check("R1 ser_out", {31'd0, ser_out}, 32'd0);
        check("R1 load_stb", {31'd0, load_stb}, 32'd1);
        check("R1 word_out", word_out, 32'd0);
        for (int a = 0; a < 4; a++) begin
            rd_addr = 2'(a);
            #1 check("R1 rd_data", rd_data, 32'd0);
        end

        // Table walk: write each pattern while running, then follow it for 160 clocks
        for (int p = 0; p < 4; p++) begin
            for (int w = 0; w < 4; w++) tick(1'b1, w, PATS[p][w*32 +: 32]);
            for (int a = 0; a < 4; a++) begin
                rd_addr = 2'(a);
                #1 check("R6 rd_data", rd_data, PATS[p][a*32 +: 32]);
            end
            for (int c = 0; c < 160; c++) tick(1'b0, 0, '0);
        end

        // R6: a written value is readable in the next cycle
        rd_addr = 2'd2;
        tick(1'b1, 2, 32'h13579BDF);
        #1 check("R6 readback next cycle", rd_data, 32'h13579BDF);

        // R5: write to a word on the same edge that loads it; the old value goes out
        while (!(m_cnt == 0 && m_idx == 1)) tick(1'b0, 0, '0);
        old_w = m_bank[1];
        tick(1'b1, 1, ~old_w);
        for (int b = 0; b < 32; b++) begin
            check("R5 old word shifted", {31'd0, ser_out}, {31'd0, old_w[b]});
            if (b == 5) begin
                wr_en = 1'b1; wr_addr = 2'd1; wr_data = 32'h0;
                @(posedge clk); m_shift = m_shift >> 1; m_cnt = (m_cnt + 1) % 32; m_bank[1] = 32'h0;
                @(negedge clk); wr_en = 1'b0; check_outputs();
            end else if (b < 31) begin
                tick(1'b0, 0, '0);
            end
        end
        // the 0 written mid-word is loaded on the next visit of word 1
        while (!(m_cnt == 0 && m_idx == 1)) tick(1'b0, 0, '0);
        check("R5 new value selected", word_out, 32'h0);

        // R7: fastest square wave
        for (int w = 0; w < 4; w++) tick(1'b1, w, 32'h55555555);
        for (int c = 0; c < 130; c++) tick(1'b0, 0, '0);
        for (int c = 0; c < 64; c++) begin
            logic prev;
            prev = ser_out;
            tick(1'b0, 0, '0);
            check("R7 toggle", {31'd0, ser_out}, {31'd0, ~prev});
        end

        // R8: 16 high then 16 low
        for (int w = 0; w < 4; w++) tick(1'b1, w, 32'h0000FFFF);
        for (int c = 0; c < 130; c++) tick(1'b0, 0, '0);
        while (m_cnt != 0) tick(1'b0, 0, '0);
        ones = 0;
        for (int c = 0; c < 32; c++) begin
            tick(1'b0, 0, '0);
            check("R8 duty", {31'd0, ser_out}, {31'd0, (c < 16)});
            ones += int'(ser_out);
        end
        check("R8 ones per period", 32'(ones), 32'd16);

        // R1: a reset in mid-run clears the words and restarts at word 0
        do_reset();
        check("R1 mid-run reset ser_out", {31'd0, ser_out}, 32'd0);
        check("R1 mid-run reset load_stb", {31'd0, load_stb}, 32'd1);
        check("R1 mid-run reset word_out", word_out, 32'd0);
        for (int c = 0; c < 40; c++) tick(1'b0, 0, '0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule